// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Detect

This block compares two divided clock-domain pulse trains, one from the reference divider and one from the RF divider, and drives up and down correction pulses toward a charge pump. Both inputs are level signals that are synchronous to the block clock. A rising edge on either input starts a correction pulse. When both pulses are active, both are cleared together after a fixed stretch of clocks. Because of this stretch, each output pulses for a minimum width even when the phase error is zero, so the detector has no dead band.

A direction input sets the sense of the loop. It swaps which input drives the up output and which drives the down output. It also swaps the two gated monitor outputs that copy the compared signals. A detector enable silences both correction outputs. A 2-bit gain code is decoded into a current multiplier, which is reported in half-unit steps.

A digital lock detector measures every comparison. The end of a comparison is marked by the coincidence (AND) of the up and down pulses. The detector counts the cycles in which only one pulse was active. It declares lock after a run of comparisons with a small error. It drops lock after a shorter run of comparisons with a large error.

Top module: `pfd_lockdet`

## Requirements
- R1: With `dirSel`=1, a rising edge of `refDiv` raises `upOut` and a rising edge of `vcoDiv` raises `downOut`. The output that starts first stays high for p+RST_DELAY cycles, where p is the number of cycles by which its input edge led the other input edge. The other output stays high for RST_DELAY cycles.
- R2: With `dirSel`=0, the roles are reversed: a rising edge of `vcoDiv` raises `upOut` and a rising edge of `refDiv` raises `downOut`. The same pulse widths as in R1 apply.
- R3: One cycle after a clock edge, `monA` carries `vcoDiv` and `monB` carries `refDiv` when `dirSel`=1. The two are exchanged when `dirSel`=0.
- R4: While `monEnable` is 0, `monA` and `monB` are 0 one cycle later, whatever the other inputs are.
- R5: While `pdEnable` is 0, `upOut` and `downOut` stay 0. Comparisons and lock tracking continue internally.
- R6: `gainMult` gives the current multiplier in half units: code 0→2 (1.0x), 1→3 (1.5x), 2→5 (2.5x), 3→8 (4.0x).
- R7: When the two edges arrive in the same cycle, both outputs go high together for exactly RST_DELAY cycles, and both outputs clear in the same cycle.
- R8: The error of a comparison is the number of cycles in which exactly one pulse is active. `locked` rises at the end of the LOCK_COUNT-th consecutive comparison whose error is at most LOCK_TOL.
- R9: `locked` falls at the end of the max(1, LOCK_COUNT/3)-th consecutive comparison whose error is above LOCK_TOL.
- R10: A comparison of the opposite kind restarts the run count. A single bad comparison neither drops lock nor lets an earlier good run carry over.
- R11: After reset, `upOut`, `downOut`, `monA`, `monB` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refDiv | input | 1 | Divided reference pulse train |
| vcoDiv | input | 1 | Divided RF pulse train |
| dirSel | input | 1 | Loop sense: 1 normal, 0 reversed |
| pdEnable | input | 1 | Enables the correction outputs |
| monEnable | input | 1 | Enables the monitor outputs |
| gainCode | input | 2 | Charge-pump gain selection |
| upOut | output | 1 | Source (up) correction pulse |
| downOut | output | 1 | Sink (down) correction pulse |
| monA | output | 1 | Monitor: divided RF when dirSel=1 |
| monB | output | 1 | Monitor: divided reference when dirSel=1 |
| gainMult | output | 4 | Current multiplier in half units |
| locked | output | 1 | Lock indication |

## Verification
A wrong pulse flip-flop or stretch counter shows up within one comparison, as an up or down width that differs from p+RST_DELAY or RST_DELAY. A wrong error counter or run counter hides until a run boundary. It then appears as `locked` moving one comparison early or late. For this reason the lock sequences place single opposite comparisons right next to the thresholds. A swapped direction path shows at once on both the monitors and the pulse outputs.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic upAct;    // up-side pulse flip-flop state
    logic dnAct;    // down-side pulse flip-flop state
    logic cmpDone;  // last cycle of the coincidence stretch
  } pfdStrobes_t;
endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int RST_DELAY = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refDiv,
  input  logic        vcoDiv,
  input  logic        dirSel,
  output pfdStrobes_t strb
);
  localparam int STR_W = (RST_DELAY < 2) ? 1 : $clog2(RST_DELAY + 1);
  localparam logic [STR_W-1:0] LAST = STR_W'(RST_DELAY - 1);

  logic refPrev, vcoPrev;
  logic upQ, dnQ;
  logic [STR_W-1:0] cnt;
  logic riseRef, riseVco, riseUp, riseDn, both;

  assign riseRef = refDiv & ~refPrev;
  assign riseVco = vcoDiv & ~vcoPrev;
  assign riseUp  = dirSel ? riseRef : riseVco;
  assign riseDn  = dirSel ? riseVco : riseRef;
  assign both    = upQ & dnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      vcoPrev <= 1'b0;
      upQ     <= 1'b0;
      dnQ     <= 1'b0;
      cnt     <= '0;
    end else begin
      refPrev <= refDiv;
      vcoPrev <= vcoDiv;
      if (both) begin
        if (cnt == LAST) begin
          upQ <= 1'b0;
          dnQ <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        upQ <= upQ | riseUp;
        dnQ <= dnQ | riseDn;
      end
    end
  end

  assign strb.upAct   = upQ;
  assign strb.dnAct   = dnQ;
  assign strb.cmpDone = both && (cnt == LAST);

  AST_STRETCH_ONLY_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> (upQ && dnQ)); // R7
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(upQ) |-> $fell(dnQ)); // R7
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int LOCK_COUNT = 6,
  parameter int LOCK_TOL   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  pfdStrobes_t strb,
  input  logic        refDiv,
  input  logic        vcoDiv,
  input  logic        dirSel,
  input  logic        pdEnable,
  input  logic        monEnable,
  input  logic [1:0]  gainCode,
  output logic        upOut,
  output logic        downOut,
  output logic        monA,
  output logic        monB,
  output logic [3:0]  gainMult,
  output logic        locked
);
  localparam int UNLOCK_COUNT = (LOCK_COUNT / 3 < 1) ? 1 : LOCK_COUNT / 3;
  localparam int ERR_MAX = LOCK_TOL + 1;
  localparam int ERR_W   = $clog2(ERR_MAX + 1);
  localparam int RUN_W   = $clog2(LOCK_COUNT + 1);
  localparam logic [ERR_W-1:0] ERR_TOP = ERR_W'(ERR_MAX);
  localparam logic [ERR_W-1:0] TOL_V   = ERR_W'(LOCK_TOL);
  localparam logic [RUN_W:0]   LOCK_N  = (RUN_W + 1)'(LOCK_COUNT);
  localparam logic [RUN_W:0]   DROP_N  = (RUN_W + 1)'(UNLOCK_COUNT);

  logic [ERR_W-1:0] errCnt;
  logic [RUN_W-1:0] goodRun, badRun;
  logic [RUN_W:0]   goodNext, badNext;
  logic             goodCmp;

  assign goodCmp  = (errCnt <= TOL_V);
  assign goodNext = {1'b0, goodRun} + (RUN_W + 1)'(1);
  assign badNext  = {1'b0, badRun} + (RUN_W + 1)'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt  <= '0;
      goodRun <= '0;
      badRun  <= '0;
      locked  <= 1'b0;
    end else if (strb.cmpDone) begin
      errCnt <= '0;
      if (goodCmp) begin
        badRun <= '0;
        if (goodNext <= LOCK_N) goodRun <= goodNext[RUN_W-1:0];
        if (goodNext >= LOCK_N) locked <= 1'b1;
      end else begin
        goodRun <= '0;
        if (badNext <= DROP_N) badRun <= badNext[RUN_W-1:0];
        if (badNext >= DROP_N) locked <= 1'b0;
      end
    end else if ((strb.upAct ^ strb.dnAct) && (errCnt != ERR_TOP)) begin
      errCnt <= errCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monA <= 1'b0;
      monB <= 1'b0;
    end else begin
      monA <= monEnable & (dirSel ? vcoDiv : refDiv);
      monB <= monEnable & (dirSel ? refDiv : vcoDiv);
    end
  end

  assign upOut   = pdEnable & strb.upAct;
  assign downOut = pdEnable & strb.dnAct;

  always_comb begin
    case (gainCode)
      2'd0:    gainMult = 4'd2;
      2'd1:    gainMult = 4'd3;
      2'd2:    gainMult = 4'd5;
      default: gainMult = 4'd8;
    endcase
  end

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= ERR_TOP); // R8
  AST_LOCK_RISE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(strb.cmpDone)); // R8
  AST_LOCK_FALL_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(strb.cmpDone)); // R9
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet
  import pfd_pkg::*;
#(
  parameter int RST_DELAY  = 2,
  parameter int LOCK_COUNT = 6,
  parameter int LOCK_TOL   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refDiv,
  input  logic       vcoDiv,
  input  logic       dirSel,
  input  logic       pdEnable,
  input  logic       monEnable,
  input  logic [1:0] gainCode,
  output logic       upOut,
  output logic       downOut,
  output logic       monA,
  output logic       monB,
  output logic [3:0] gainMult,
  output logic       locked
);
  pfdStrobes_t strb;

  pfd_ctrl #(.RST_DELAY(RST_DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN), .refDiv(refDiv), .vcoDiv(vcoDiv),
    .dirSel(dirSel), .strb(strb)
  );

  pfd_datapath #(.LOCK_COUNT(LOCK_COUNT), .LOCK_TOL(LOCK_TOL)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .refDiv(refDiv), .vcoDiv(vcoDiv),
    .dirSel(dirSel), .pdEnable(pdEnable), .monEnable(monEnable),
    .gainCode(gainCode), .upOut(upOut), .downOut(downOut), .monA(monA),
    .monB(monB), .gainMult(gainMult), .locked(locked)
  );
endmodule

// File: tb/pfd_lockdet_tb.sv
module pfd_lockdet_tb;
  localparam int D = 2;
  localparam int LCNT = 6;
  localparam int TOL = 1;
  localparam int DROP = LCNT / 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refDiv = 1'b0, vcoDiv = 1'b0, dirSel = 1'b1;
  logic pdEnable = 1'b1, monEnable = 1'b0;
  logic [1:0] gainCode = 2'd0;
  logic upOut, downOut, monA, monB, locked;
  logic [3:0] gainMult;

  int checks = 0;
  int failures = 0;
  int goodRun = 0, badRun = 0;
  int expLocked = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pfd_lockdet #(.RST_DELAY(D), .LOCK_COUNT(LCNT), .LOCK_TOL(TOL)) u_dut (
    .clk(clk), .rstN(rstN), .refDiv(refDiv), .vcoDiv(vcoDiv),
    .dirSel(dirSel), .pdEnable(pdEnable), .monEnable(monEnable),
    .gainCode(gainCode), .upOut(upOut), .downOut(downOut), .monA(monA),
    .monB(monB), .gainMult(gainMult), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // One comparison: leading input rises, the other follows p cycles later.
  task automatic doCompare(input logic dir, input logic refFirst, input int p,
                           input logic en, input string tag);
    int upCnt = 0, dnCnt = 0, expUp, expDn;
    bit leadIsUp;
    dirSel = dir;
    pdEnable = en;
    step(2);
    if (refFirst) refDiv = 1'b1; else vcoDiv = 1'b1;
    if (p == 0) begin refDiv = 1'b1; vcoDiv = 1'b1; end
    for (int i = 1; i <= p + D + 6; i++) begin
      @(posedge clk);
      #1;
      upCnt += int'(upOut);
      dnCnt += int'(downOut);
      if (i == p) begin refDiv = 1'b1; vcoDiv = 1'b1; end
    end
    leadIsUp = (dir == refFirst);
    expUp = en ? (leadIsUp ? p + D : D) : 0;
    expDn = en ? (leadIsUp ? D : p + D) : 0;
    chk({tag, " up width"}, upCnt, expUp);
    chk({tag, " down width"}, dnCnt, expDn);
    // lock model (R8, R9, R10)
    if (p <= TOL) begin
      badRun = 0; goodRun++;
      if (goodRun >= LCNT) expLocked = 1;
    end else begin
      goodRun = 0; badRun++;
      if (badRun >= DROP) expLocked = 0;
    end
    chk("R8/R9/R10 locked", int'(locked), expLocked);
    refDiv = 1'b0;
    vcoDiv = 1'b0;
    step(3);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R11 reset state
    chk("R11 upOut", int'(upOut), 0);
    chk("R11 downOut", int'(downOut), 0);
    chk("R11 monA", int'(monA), 0);
    chk("R11 monB", int'(monB), 0);
    chk("R11 locked", int'(locked), 0);

    // R6 gain decode
    for (int g = 0; g < 4; g++) begin
      gainCode = 2'(g);
      #1;
      chk("R6 gainMult", int'(gainMult), (g == 0) ? 2 : (g == 1) ? 3 : (g == 2) ? 5 : 8);
    end

    // R3 / R4 monitor sweep
    for (int cfg = 0; cfg < 16; cfg++) begin
      dirSel = cfg[0];
      monEnable = cfg[1];
      refDiv = cfg[2];
      vcoDiv = cfg[3];
      step(1);
      chk(cfg[1] ? "R3 monA" : "R4 monA", int'(monA),
          int'(cfg[1] & (cfg[0] ? cfg[3] : cfg[2])));
      chk(cfg[1] ? "R3 monB" : "R4 monB", int'(monB),
          int'(cfg[1] & (cfg[0] ? cfg[2] : cfg[3])));
    end
    refDiv = 1'b0;
    vcoDiv = 1'b0;
    monEnable = 1'b0;
    step(3);

    // R1 / R2 / R7 sweep over direction, leader and lead time
    for (int d = 1; d >= 0; d--)
      for (int rf = 0; rf < 2; rf++)
        for (int p = 0; p <= 4; p++)
          doCompare(d[0], rf[0], p, 1'b1,
                    (p == 0) ? "R7 zero error" : (d == 1) ? "R1" : "R2");

    // R5 detector disabled: outputs quiet, lock tracking continues
    for (int k = 0; k < 3; k++) doCompare(1'b1, 1'b1, 3, 1'b0, "R5");

    // R10 / R8: five good, one bad, then a full good run
    for (int k = 0; k < 5; k++) doCompare(1'b1, 1'b0, 1, 1'b1, "R8");
    doCompare(1'b1, 1'b1, 2, 1'b1, "R10");
    chk("R10 not locked after broken run", int'(locked), 0);
    for (int k = 0; k < LCNT; k++) doCompare(1'b0, 1'b1, 0, 1'b1, "R8");
    chk("R8 locked after full run", int'(locked), 1);

    // R9 / R10: isolated bad comparisons keep lock, a bad run drops it
    doCompare(1'b1, 1'b1, 4, 1'b1, "R10");
    chk("R10 single bad keeps lock", int'(locked), 1);
    doCompare(1'b1, 1'b1, 1, 1'b0, "R10");
    doCompare(1'b1, 1'b0, 3, 1'b1, "R10");
    chk("R10 bad run restarted", int'(locked), 1);
    doCompare(1'b0, 1'b0, 2, 1'b1, "R9");
    chk("R9 dropped after bad run", int'(locked), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule